// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, frame by frame, whether a frame should be kept. The frame parser hands over the 48-bit destination address with a one-cycle request strobe. Two clock edges later the block returns a one-cycle response that carries an accept or reject verdict. Frame parsing, CRC checking and statistics belong to other blocks.

The verdict is built from three sources. The first is a bank of eight exact-match station addresses. The second is a 64-bucket hash table that admits multicast (group) addresses. The third is a promiscuous override that admits everything. All of these are programmed through a simple word-indexed register write port. The hash table is never written as a whole: a single control word sets or clears one bucket per write.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, rsp_valid is 0, every station entry is all zeros, every hash bucket is clear and promiscuous mode is off, so every request is rejected.
- R2: A request sampled at clock edge k produces rsp_valid high for exactly one cycle after edge k+1. The verdict uses the configuration as it stood before edge k, so a register write in the same cycle as the request is not yet seen.
- R3: Station entry s is written through index 2s (low word) and index 2s+1 (upper word). The address is taken with octet 0 as its most significant byte (req_dst[47:40]). The low word holds octet 0 in bits 7:0, octet 1 in 15:8, octet 2 in 23:16 and octet 3 in 31:24. The upper word holds octet 4 in bits 7:0 and octet 5 in 15:8, and its bits 31:16 are ignored.
- R4: A destination equal to any of the eight station entries is accepted.
- R5: A station entry that holds the all-zero address is invalid and never matches, so an all-zero destination is never accepted through the station bank.
- R6: The 6-bit hash code has bit j equal to the XOR of the eight bits of octet j (j = 0..5, with octet 0 = req_dst[47:40]).
- R7: A write to index 16 (the hash control word) sets the bucket named by bits 5:0 when bit 8 is 1, and clears it when bit 8 is 0. All other buckets keep their state.
- R8: A destination is a group address when bit 0 of octet 0 (req_dst[40]) is 1. Only group addresses are accepted through the hash table.
- R9: When bit 0 of index 17 (the mode word) is 1, every request is accepted. Writing 0 to it restores filtering.
- R10: A request that matches no station entry, is not a group address with a set bucket, and arrives with promiscuous mode off is rejected.
- R11: Writes to indices 18 to 31 change no filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Destination lookup request strobe |
| req_dst | input | 48 | Destination address, octet 0 in bits 47:40 |
| rsp_valid | output | 1 | Verdict valid, two edges after the request |
| rsp_accept | output | 1 | 1 = accept frame, 0 = reject |

## Verification
On every cycle, the assertions check the two-edge request-to-response spacing and that the promiscuous state captured with a request forces acceptance. They also check that a unicast frame accepted outside promiscuous mode had a station hit, that a hash control write lands in the named bucket, and that an all-zero destination never raises a station hit. Only the bench scenarios can show the byte order of the station words, the exact bit order of the hash fold, that other buckets survive a single-bucket write, that writes to unused indices and to the upper half of the upper word have no effect, and that a write in the same cycle as a request is not seen.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int MAC_W     = 48;
    localparam int OCTETS    = MAC_W / 8;
    localparam int HASH_W    = OCTETS;
    localparam int BUCKETS   = 1 << HASH_W;
    localparam int HCTL_EN_B = 8;
    localparam int GROUP_B   = MAC_W - 8;

    typedef logic [MAC_W-1:0]  mac_t;
    typedef logic [HASH_W-1:0] hidx_t;

    // Octet 0 of the address is the most significant byte.
    function automatic mac_t join_words(input logic [31:0] lo, input logic [15:0] hi);
        return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
    endfunction

    // Bit j of the code is the parity of octet j.
    function automatic hidx_t fold_hash(input mac_t a);
        hidx_t h;
        for (int j = 0; j < HASH_W; j++) begin
            h[j] = ^a[MAC_W-1-8*j -: 8];
        end
        return h;
    endfunction

endpackage

// File: rtl/daf_station_table.sv
module daf_station_table
    import daf_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  mac_t          dst,
    output logic [N-1:0]  hit_o
);

    typedef struct packed {
        logic [N-1:0][31:0] lo;
        logic [N-1:0][15:0] hi;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N; k++) begin
            if (wr_en && wr_idx == AW'(2 * k)) begin
                st_d.lo[k] = wr_data;
            end
            if (wr_en && wr_idx == AW'(2 * k + 1)) begin
                st_d.hi[k] = wr_data[15:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        mac_t entry;
        assign entry    = join_words(st_q.lo[g], st_q.hi[g]);
        assign hit_o[g] = (|entry) && (entry == dst);
    end

endmodule

// File: rtl/daf_hash_table.sv
module daf_hash_table
    import daf_pkg::*;
#(
    parameter int AW      = 5,
    parameter int CTL_IDX = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [31:0]        wr_data,
    input  hidx_t              look_idx,
    output logic               bucket_hit,
    output logic [BUCKETS-1:0] buckets_o
);

    typedef struct packed {
        logic [BUCKETS-1:0] bkt;
    } ht_t;

    ht_t ht_d, ht_q;

    always_comb begin
        ht_d = ht_q;
        if (wr_en && wr_idx == AW'(CTL_IDX)) begin
            ht_d.bkt[wr_data[HASH_W-1:0]] = wr_data[HCTL_EN_B];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ht_q <= '0;
        end else begin
            ht_q <= ht_d;
        end
    end

    assign bucket_hit = ht_q.bkt[look_idx];
    assign buckets_o  = ht_q.bkt;

endmodule

// File: rtl/daf_verdict.sv
module daf_verdict #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [N-1:0] hit_vec,
    input  logic         is_group,
    input  logic         bucket_hit,
    input  logic         promisc,
    output logic         rsp_valid,
    output logic         rsp_accept
);

    typedef struct packed {
        logic         s1_v;
        logic [N-1:0] s1_hit;
        logic         s1_grp;
        logic         s1_bkt;
        logic         s1_prom;
        logic         s2_v;
        logic         s2_acc;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d         = p_q;
        p_d.s1_v    = req_valid;
        p_d.s1_hit  = req_valid ? hit_vec : '0;
        p_d.s1_grp  = req_valid && is_group;
        p_d.s1_bkt  = req_valid && bucket_hit;
        p_d.s1_prom = req_valid && promisc;
        p_d.s2_v    = p_q.s1_v;
        p_d.s2_acc  = p_q.s1_v && (p_q.s1_prom || (|p_q.s1_hit) || (p_q.s1_grp && p_q.s1_bkt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rsp_valid  = p_q.s2_v;
    assign rsp_accept = p_q.s2_acc;

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
#(
    parameter int N_STATIONS = 8,
    parameter int IDX_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_wdata,
    input  logic             req_valid,
    input  logic [47:0]      req_dst,
    output logic             rsp_valid,
    output logic             rsp_accept
);

    localparam int HASH_IDX = 2 * N_STATIONS;
    localparam int MODE_IDX = 2 * N_STATIONS + 1;

    logic                  prom_d, prom_q;
    logic [N_STATIONS-1:0] hit_vec;
    logic                  bucket_hit;
    logic [BUCKETS-1:0]    buckets;
    hidx_t                 hidx;

    always_comb begin
        prom_d = prom_q;
        if (cfg_we && cfg_idx == IDX_W'(MODE_IDX)) begin
            prom_d = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prom_q <= 1'b0;
        end else begin
            prom_q <= prom_d;
        end
    end

    assign hidx = fold_hash(req_dst);

    daf_station_table #(
        .N  (N_STATIONS),
        .AW (IDX_W)
    ) u_station (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .dst     (req_dst),
        .hit_o   (hit_vec)
    );

    daf_hash_table #(
        .AW      (IDX_W),
        .CTL_IDX (HASH_IDX)
    ) u_hash (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_data    (cfg_wdata),
        .look_idx   (hidx),
        .bucket_hit (bucket_hit),
        .buckets_o  (buckets)
    );

    daf_verdict #(
        .N (N_STATIONS)
    ) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .hit_vec    (hit_vec),
        .is_group   (req_dst[GROUP_B]),
        .bucket_hit (bucket_hit),
        .promisc    (prom_q),
        .rsp_valid  (rsp_valid),
        .rsp_accept (rsp_accept)
    );

endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
    parameter int N        = 8,
    parameter int AW       = 5,
    parameter int HASH_IDX = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_idx,
    input logic [31:0]   cfg_wdata,
    input logic          req_valid,
    input logic [47:0]   req_dst,
    input logic          rsp_valid,
    input logic          rsp_accept,
    input logic          prom_q,
    input logic [N-1:0]  hit_vec,
    input logic [63:0]   buckets
);

    assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    assert_rsp_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    assert_promisc_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(prom_q, 2)) |-> rsp_accept);

    assert_unicast_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_accept && !$past(prom_q, 2) && !$past(req_dst[40], 2))
            |-> $past(|hit_vec, 2));

    assert_bucket_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == AW'(HASH_IDX))
            |=> (buckets[$past(cfg_wdata[5:0])] == $past(cfg_wdata[8])));

    assert_zero_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_dst == 48'h0) |-> (hit_vec == '0));

endmodule

bind dest_addr_filter daf_checker #(
    .N        (N_STATIONS),
    .AW       (IDX_W),
    .HASH_IDX (HASH_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .req_valid  (req_valid),
    .req_dst    (req_dst),
    .rsp_valid  (rsp_valid),
    .rsp_accept (rsp_accept),
    .prom_q     (prom_q),
    .hit_vec    (hit_vec),
    .buckets    (buckets)
);

// File: tb/tb_dest_addr_filter.sv
`timescale 1ns/1ps
module tb_dest_addr_filter;

    localparam int HCTL = 16;
    localparam int MODE = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [47:0] req_dst = '0;
    logic        rsp_valid;
    logic        rsp_accept;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dest_addr_filter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .req_valid  (req_valid),
        .req_dst    (req_dst),
        .rsp_valid  (rsp_valid),
        .rsp_accept (rsp_accept)
    );

    typedef struct packed {
        logic        is_req;
        logic [4:0]  idx;
        logic [47:0] data;
        logic        exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd0,  48'h0000_3322_1102, 1'b0, 4'd3},  // R3 station 0 low
        '{1'b0, 5'd1,  48'h0000_0000_5544, 1'b0, 4'd3},  // R3 station 0 upper
        '{1'b0, 5'd14, 48'h0000_DDCC_BB0A, 1'b0, 4'd3},  // R3 station 7 low
        '{1'b0, 5'd15, 48'h0000_ABCD_F0EE, 1'b0, 4'd3},  // R3 upper half ignored
        '{1'b0, 5'd7,  48'h0000_0000_0100, 1'b0, 4'd4},  // R4 station 3 upper only
        '{1'b1, 5'd0,  48'h0211_2233_4455, 1'b1, 4'd4},  // R4 station 0
        '{1'b1, 5'd0,  48'h0ABB_CCDD_EEF0, 1'b1, 4'd3},  // R3 station 7 despite upper junk
        '{1'b1, 5'd0,  48'h0000_0000_0001, 1'b1, 4'd4},  // R4 station 3
        '{1'b1, 5'd0,  48'h0211_2233_4456, 1'b0, 4'd10}, // R10 near miss
        '{1'b1, 5'd0,  48'h0000_0000_0000, 1'b0, 4'd5},  // R5 zero entries invalid
        '{1'b1, 5'd0,  48'h0100_5E00_0001, 1'b0, 4'd8},  // R8 group, bucket clear
        '{1'b1, 5'd0,  48'h5544_3322_1102, 1'b0, 4'd3}   // R3 reversed byte order
    };

    function automatic logic [5:0] h6(input logic [47:0] a);
        logic [5:0] r;
        for (int j = 0; j < 6; j++) begin
            r[j] = ^a[47-8*j -: 8];
        end
        return r;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a request, sample the response at the negedge after edge k+1.
    task automatic lookup(input logic [47:0] a, output logic v1, output logic v2, output logic acc);
        @(negedge clk);
        req_valid = 1'b1; req_dst = a;
        @(negedge clk);
        req_valid = 1'b0;
        v1 = rsp_valid;
        @(negedge clk);
        v2 = rsp_valid;
        acc = rsp_accept;
    endtask

    task automatic expect_verdict(input logic [47:0] a, input logic exp, input string tag);
        logic v1, v2, acc;
        lookup(a, v1, v2, acc);
        chk(v2 && acc, exp, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        logic v1, v2, v3, acc;
        logic [5:0] hb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(rsp_valid, 1'b0, "R1 rsp_valid after reset");
        expect_verdict(48'h0211_2233_4455, 1'b0, "R1 unicast after reset");
        expect_verdict(48'h0100_5E00_0001, 1'b0, "R1 group after reset");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (!VECS[i].is_req) begin
                wr(int'(VECS[i].idx), VECS[i].data[31:0]);
            end else begin
                expect_verdict(VECS[i].data, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].rq, i));
            end
        end

        // R2: response spacing
        lookup(48'h0211_2233_4455, v1, v2, acc);
        @(negedge clk);
        v3 = rsp_valid;
        chk(v1, 1'b0, "R2 not valid after one edge");
        chk(v2, 1'b1, "R2 valid after two edges");
        chk(v3, 1'b0, "R2 single-cycle pulse");

        // R2: write in the same cycle as the request is not seen
        wr(5, 32'h0000_9988);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'd4; cfg_wdata = 32'h7766_5504;
        req_valid = 1'b1; req_dst = 48'h0455_6677_8899;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && rsp_accept, 1'b0, "R2 same-cycle write unseen");
        expect_verdict(48'h0455_6677_8899, 1'b1, "R2 write seen afterwards");

        // R6/R7: hash bucket of a group address
        hb = h6(48'h0100_5E00_0001);
        wr(HCTL, 32'h100 | 32'(hb));
        expect_verdict(48'h0100_5E00_0001, 1'b1, "R6 R7 group accepted via bucket");
        expect_verdict(48'h0100_5E00_0003, 1'b0, "R6 other bucket clear");
        // R8: unicast with the same hash is not accepted
        expect_verdict(48'h0200_5E00_0001, 1'b0, "R8 unicast ignores hash");
        // R7: touching another bucket leaves this one alone
        wr(HCTL, 32'h100 | 32'(hb ^ 6'h21));
        wr(HCTL, 32'(hb ^ 6'h21));
        expect_verdict(48'h0100_5E00_0001, 1'b1, "R7 bucket kept after neighbour write");
        wr(HCTL, 32'(hb));
        expect_verdict(48'h0100_5E00_0001, 1'b0, "R7 bucket cleared");

        // R9: promiscuous
        wr(MODE, 32'h1);
        expect_verdict(48'h0A0B_0C0D_0E0F, 1'b1, "R9 promiscuous unicast");
        expect_verdict(48'h0000_0000_0000, 1'b1, "R9 promiscuous zero");
        wr(MODE, 32'h0);
        expect_verdict(48'h0A0B_0C0D_0E0F, 1'b0, "R9 filtering restored");

        // R11: unused indices
        for (int k = 18; k < 32; k++) wr(k, 32'hFFFF_FFFF);
        expect_verdict(48'h0A0B_0C0D_0E0F, 1'b0, "R11 unused index no promisc");
        expect_verdict(48'h0211_2233_4455, 1'b1, "R11 station 0 intact");

        // R5: clearing an entry makes it invalid
        wr(0, 32'h0); wr(1, 32'h0);
        expect_verdict(48'h0211_2233_4455, 1'b0, "R5 cleared entry no match");
        expect_verdict(48'h0000_0000_0000, 1'b0, "R5 zero destination");

        // R1: reset again wipes configuration
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        expect_verdict(48'h0ABB_CCDD_EEF0, 1'b0, "R1 station cleared by reset");

        finish_run();
    end

endmodule